// File: doc/BRIEF.md
# Programmable Sum-of-Products Array with Output Polarity

This block is a small field-configurable two-level logic array. Three input bits feed an AND plane of four product terms. For each term, configuration state decides whether each input is used in true form, in complemented form, or not at all. A fourth literal code removes the term altogether. An OR plane that is also configured decides which terms drive each of the two outputs. A final stage per output can pass the OR result through unchanged or invert it.

Configuration is loaded one word at a time through a synchronous write port. Words at addresses 0 to 3 each describe one product term, and the word at address 4 holds the output polarity bits. Once the array is loaded, evaluation from `in_vec` to `out_vec` is purely combinational. It behaves like a small PLA that can be reprogrammed at run time, and only the configured terms exist, not every minterm.

Top module: `pla_sop_array`

## Requirements
- R1: After a clock edge with `rst_n` low, every literal is absent, no term is connected to any output and both outputs are in true polarity, so `out_vec` is 0 for every input value.
- R2: Literal code 2'b01 (true) for input i makes the term require `in_vec[i]`=1. The literal of input i is `cfg_data[2i+1:2i]` of a term word, so input 2 uses bits 5:4, input 1 uses bits 3:2 and input 0 uses bits 1:0.
- R3: Literal code 2'b10 (complemented) for input i makes the term require `in_vec[i]`=0.
- R4: Literal code 2'b11 on any input forces that product term to 0, whatever the other literals and the inputs are.
- R5: A product term whose literals are all code 2'b00 (absent) evaluates to 1 for every input value.
- R6: Output j is the OR of every term whose word has connect bit `cfg_data[6+j]` set. An output with no connected term gives 0 before its polarity stage.
- R7: Bit j of the polarity word (address 4, `cfg_data[j]`) inverts output j when it is 1 and passes the OR result when it is 0.
- R8: A write takes effect on the clock edge where `cfg_we` is high. During the cycle of the write the outputs still reflect the old settings. Writes to addresses 5 to 7, and cycles with `cfg_we` low, change no setting.
- R9: Loaded with terms AB', AC, BC and A'BC' (A=`in_vec[2]`, B=`in_vec[1]`, C=`in_vec[0]`), with out 0 = AB'+AC+A'BC' in true form and out 1 = (AC+BC)' in inverted form, the array produces both functions over all 8 input values.
- R10: `out_vec` follows a change of `in_vec` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset of the configuration |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 3 | Word address: 0..3 product terms, 4 polarity |
| cfg_data | input | 8 | Term word {connect[1:0], lit2, lit1, lit0} or polarity word {6'b0, inv[1:0]} |
| in_vec | input | 3 | Logic inputs evaluated by the array |
| out_vec | output | 2 | Combinational array outputs after polarity |

## Verification
A corrupted literal register shows up at the outputs for exactly the input values that the wrong literal admits or rejects. Only a sweep of all eight inputs under each literal code exposes it, and it appears in the same cycle the input is applied. A connect or polarity bit in the wrong state flips an output for whole sets of inputs, so a single sweep after each write catches it. A write that lands a cycle early or late, or at an address that should be ignored, is seen at the ports as a change in the probe taken during the write cycle or in the sweep that follows.

// File: rtl/pla_pkg.sv
// Package: shared sizes and literal encoding for the sum-of-products array.
// Assumes every consumer takes its widths from these defaults or overrides them consistently.
package pla_pkg;

    localparam int unsigned DEF_NUM_IN    = 3;
    localparam int unsigned DEF_NUM_TERMS = 4;
    localparam int unsigned DEF_NUM_OUT   = 2;

    // Two-bit literal code held per input per product term.
    typedef enum logic [1:0] {
        LIT_ABSENT = 2'b00,
        LIT_TRUE   = 2'b01,
        LIT_COMP   = 2'b10,
        LIT_KILL   = 2'b11
    } lit_code_e;

endpackage

// File: rtl/pla_cfg_regs.sv
// Module: configuration store of the array.
// Holds one literal word and one connect field per product term, plus a polarity word.
// Address t < NUM_TERMS loads term t; address NUM_TERMS loads polarity; others are dropped.
// Assumes a synchronous active-low reset that clears everything to the neutral setting.
module pla_cfg_regs #(
    parameter int unsigned NUM_IN    = pla_pkg::DEF_NUM_IN,
    parameter int unsigned NUM_TERMS = pla_pkg::DEF_NUM_TERMS,
    parameter int unsigned NUM_OUT   = pla_pkg::DEF_NUM_OUT,
    localparam int unsigned LIT_W    = 2 * NUM_IN,
    localparam int unsigned DATA_W   = LIT_W + NUM_OUT,
    localparam int unsigned ADDR_W   = $clog2(NUM_TERMS + 1)
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_we,
    input  logic [ADDR_W-1:0]                         cfg_addr,
    input  logic [DATA_W-1:0]                         cfg_data,
    output logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0]     lit_q,
    output logic [NUM_TERMS-1:0][NUM_OUT-1:0]         conn_q,
    output logic [NUM_OUT-1:0]                        inv_q
);

    logic [NUM_TERMS-1:0] term_sel;
    logic                 pol_sel;

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        // Decode a write aimed at this product term.
        assign term_sel[t] = cfg_we && (cfg_addr == ADDR_W'(t));

        // Load this term's literals and output connections.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lit_q[t]  <= '0;
                conn_q[t] <= '0;
            end else if (term_sel[t]) begin
                for (int i = 0; i < int'(NUM_IN); i++) begin
                    lit_q[t][i] <= cfg_data[2*i +: 2];
                end
                conn_q[t] <= cfg_data[LIT_W +: NUM_OUT];
            end
        end
    end

    // Decode a write aimed at the polarity word.
    assign pol_sel = cfg_we && (cfg_addr == ADDR_W'(NUM_TERMS));

    // Load the output polarity bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inv_q <= '0;
        end else if (pol_sel) begin
            inv_q <= cfg_data[NUM_OUT-1:0];
        end
    end

endmodule

// File: rtl/pla_and_plane.sv
// Module: programmable AND plane.
// Each term is the AND of its literals; an absent literal contributes 1, a kill literal 0.
// Assumes both polarities of each input are available, built here from in_vec.
module pla_and_plane #(
    parameter int unsigned NUM_IN    = pla_pkg::DEF_NUM_IN,
    parameter int unsigned NUM_TERMS = pla_pkg::DEF_NUM_TERMS
) (
    input  logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0] lit_q,
    input  logic [NUM_IN-1:0]                     in_vec,
    output logic [NUM_TERMS-1:0]                  term_vec
);

    import pla_pkg::*;

    logic [NUM_IN-1:0] in_true;
    logic [NUM_IN-1:0] in_comp;

    // Provide both true and complemented rails of every input.
    always_comb begin
        in_true = in_vec;
        in_comp = ~in_vec;
    end

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [NUM_IN-1:0] lit_ok;

        for (genvar i = 0; i < NUM_IN; i++) begin : g_lit
            // Evaluate one literal of this term against the input rails.
            always_comb begin
                unique case (lit_code_e'(lit_q[t][i]))
                    LIT_ABSENT: lit_ok[i] = 1'b1;
                    LIT_TRUE:   lit_ok[i] = in_true[i];
                    LIT_COMP:   lit_ok[i] = in_comp[i];
                    default:    lit_ok[i] = 1'b0;
                endcase
            end
        end

        assign term_vec[t] = &lit_ok;
    end

endmodule

// File: rtl/pla_or_plane.sv
// Module: programmable OR plane.
// Each output ORs the terms whose connect bit for that output is set; none set gives 0.
// Assumes term_vec is already settled from the AND plane.
module pla_or_plane #(
    parameter int unsigned NUM_TERMS = pla_pkg::DEF_NUM_TERMS,
    parameter int unsigned NUM_OUT   = pla_pkg::DEF_NUM_OUT
) (
    input  logic [NUM_TERMS-1:0]              term_vec,
    input  logic [NUM_TERMS-1:0][NUM_OUT-1:0] conn_q,
    output logic [NUM_OUT-1:0]                sum_vec
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic [NUM_TERMS-1:0] hit;

        // Gate every term by its connection to this output and OR the results.
        always_comb begin
            for (int t = 0; t < int'(NUM_TERMS); t++) begin
                hit[t] = term_vec[t] & conn_q[t][o];
            end
            sum_vec[o] = |hit;
        end
    end

endmodule

// File: rtl/pla_out_pol.sv
// Module: per-output true/complement stage after the OR plane.
// Assumes inv_q bit j set means output j is inverted.
module pla_out_pol #(
    parameter int unsigned NUM_OUT = pla_pkg::DEF_NUM_OUT
) (
    input  logic [NUM_OUT-1:0] sum_vec,
    input  logic [NUM_OUT-1:0] inv_q,
    output logic [NUM_OUT-1:0] out_vec
);

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        // Select the true or complemented form of this sum.
        always_comb begin
            if (inv_q[o]) begin
                out_vec[o] = ~sum_vec[o];
            end else begin
                out_vec[o] = sum_vec[o];
            end
        end
    end

endmodule

// File: rtl/pla_sop_array.sv
// Module: top of the programmable sum-of-products array.
// Configuration store feeds an AND plane, an OR plane and a polarity stage.
// Assumes configuration is loaded before outputs are used; evaluation is combinational.
module pla_sop_array #(
    parameter int unsigned NUM_IN    = pla_pkg::DEF_NUM_IN,
    parameter int unsigned NUM_TERMS = pla_pkg::DEF_NUM_TERMS,
    parameter int unsigned NUM_OUT   = pla_pkg::DEF_NUM_OUT,
    localparam int unsigned DATA_W   = 2 * NUM_IN + NUM_OUT,
    localparam int unsigned ADDR_W   = $clog2(NUM_TERMS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_data,
    input  logic [NUM_IN-1:0] in_vec,
    output logic [NUM_OUT-1:0] out_vec
);

    logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0] lit_q;
    logic [NUM_TERMS-1:0][NUM_OUT-1:0]     conn_q;
    logic [NUM_OUT-1:0]                    inv_q;
    logic [NUM_TERMS-1:0]                  term_vec;
    logic [NUM_OUT-1:0]                    sum_vec;

    pla_cfg_regs #(
        .NUM_IN    (NUM_IN),
        .NUM_TERMS (NUM_TERMS),
        .NUM_OUT   (NUM_OUT)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .lit_q    (lit_q),
        .conn_q   (conn_q),
        .inv_q    (inv_q)
    );

    pla_and_plane #(
        .NUM_IN    (NUM_IN),
        .NUM_TERMS (NUM_TERMS)
    ) u_and (
        .lit_q    (lit_q),
        .in_vec   (in_vec),
        .term_vec (term_vec)
    );

    pla_or_plane #(
        .NUM_TERMS (NUM_TERMS),
        .NUM_OUT   (NUM_OUT)
    ) u_or (
        .term_vec (term_vec),
        .conn_q   (conn_q),
        .sum_vec  (sum_vec)
    );

    pla_out_pol #(
        .NUM_OUT (NUM_OUT)
    ) u_pol (
        .sum_vec (sum_vec),
        .inv_q   (inv_q),
        .out_vec (out_vec)
    );

endmodule

// File: rtl/pla_sop_array_chk.sv
// Module: assertion checker bound to pla_sop_array.
// Watches ports and the signals passed between the planes; drives nothing.
module pla_sop_array_chk #(
    parameter int unsigned NUM_IN    = pla_pkg::DEF_NUM_IN,
    parameter int unsigned NUM_TERMS = pla_pkg::DEF_NUM_TERMS,
    parameter int unsigned NUM_OUT   = pla_pkg::DEF_NUM_OUT,
    localparam int unsigned ADDR_W   = $clog2(NUM_TERMS + 1)
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  cfg_we,
    input logic [ADDR_W-1:0]                     cfg_addr,
    input logic [NUM_IN-1:0]                     in_vec,
    input logic [NUM_OUT-1:0]                    out_vec,
    input logic [NUM_TERMS-1:0][NUM_IN-1:0][1:0] lit_q,
    input logic [NUM_TERMS-1:0][NUM_OUT-1:0]     conn_q,
    input logic [NUM_TERMS-1:0]                  term_vec,
    input logic [NUM_OUT-1:0]                    sum_vec
);

    logic rst_seen;
    logic run_seen;

    // Track that a reset edge and then a running edge have been observed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen <= 1'b1;
            run_seen <= 1'b0;
        end else begin
            run_seen <= 1'b1;
        end
    end

    // R1
    reset_clears_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_seen && $past(!rst_n)) |-> (out_vec == '0));

    // R8
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seen && !$past(cfg_we) && $stable(in_vec)) |-> $stable(out_vec));

    // R8
    ignored_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_seen && $past(cfg_we) && ($past(cfg_addr) > ADDR_W'(NUM_TERMS))
         && $stable(in_vec)) |-> $stable(out_vec));

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic has_kill;

        // Flag a kill code anywhere in this term.
        always_comb begin
            has_kill = 1'b0;
            for (int i = 0; i < int'(NUM_IN); i++) begin
                if (lit_q[t][i] == 2'b11) has_kill = 1'b1;
            end
        end

        // R4
        kill_term_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            has_kill |-> !term_vec[t]);

        // R5
        empty_term_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (lit_q[t] == '0) |-> term_vec[t]);
    end

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
        logic any_conn;

        // Collect whether any term is wired to this output.
        always_comb begin
            any_conn = 1'b0;
            for (int t = 0; t < int'(NUM_TERMS); t++) begin
                any_conn = any_conn | conn_q[t][o];
            end
        end

        // R6
        unwired_sum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !any_conn |-> !sum_vec[o]);
    end

endmodule

bind pla_sop_array pla_sop_array_chk #(
    .NUM_IN    (NUM_IN),
    .NUM_TERMS (NUM_TERMS),
    .NUM_OUT   (NUM_OUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_addr (cfg_addr),
    .in_vec   (in_vec),
    .out_vec  (out_vec),
    .lit_q    (lit_q),
    .conn_q   (conn_q),
    .term_vec (term_vec),
    .sum_vec  (sum_vec)
);

// File: tb/pla_sop_array_tb.sv
// Scoreboard bench: driver tasks queue expected outputs, a monitor compares mid-cycle.
module pla_sop_array_tb;

    logic       clk;
    logic       rst_n;
    logic       cfg_we;
    logic [2:0] cfg_addr;
    logic [7:0] cfg_data;
    logic [2:0] in_vec;
    logic [1:0] out_vec;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [1:0] exp;
        logic [2:0] stim;
        string      req;
    } item_t;

    item_t sb_q[$];

    // Independent model of the configuration, filled from the requirements.
    logic [1:0] mdl_lit [4][3];
    logic [1:0] mdl_conn [4];
    logic [1:0] mdl_inv;

    pla_sop_array u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_data (cfg_data),
        .in_vec   (in_vec),
        .out_vec  (out_vec)
    );

    initial begin
        clk = 1'b0;
        forever #10 clk = ~clk;
    end

    function automatic logic [1:0] model_out(input logic [2:0] x);
        logic [1:0] s;
        logic       p;
        s = 2'b00;
        for (int t = 0; t < 4; t++) begin
            p = 1'b1;
            for (int i = 0; i < 3; i++) begin
                case (mdl_lit[t][i])
                    2'b01: p = p & x[i];
                    2'b10: p = p & ~x[i];
                    2'b11: p = 1'b0;
                    default: ;
                endcase
            end
            if (p) s = s | mdl_conn[t];
        end
        return s ^ mdl_inv;
    endfunction

    task automatic model_clear();
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < 3; i++) mdl_lit[t][i] = 2'b00;
            mdl_conn[t] = 2'b00;
        end
        mdl_inv = 2'b00;
    endtask

    // Apply one input value and queue the model's expectation.
    task automatic check(input logic [2:0] x, input string req);
        @(posedge clk);
        #2;
        in_vec = x;
        sb_q.push_back('{model_out(x), x, req});
    endtask

    // Apply one input value with an explicitly computed expectation.
    task automatic check_val(input logic [2:0] x, input logic [1:0] e, input string req);
        @(posedge clk);
        #2;
        in_vec = x;
        sb_q.push_back('{e, x, req});
    endtask

    task automatic sweep(input string req);
        for (int x = 0; x < 8; x++) check(3'(x), req);
    endtask

    // Write one word; probe the old output during the write cycle (R8).
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk);
        #2;
        cfg_we   = 1'b1;
        cfg_addr = a;
        cfg_data = d;
        sb_q.push_back('{model_out(in_vec), in_vec, "R8"});
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (a < 3'd4) begin
            for (int i = 0; i < 3; i++) mdl_lit[a[1:0]][i] = d[2*i +: 2];
            mdl_conn[a[1:0]] = d[7:6];
        end else if (a == 3'd4) begin
            mdl_inv = d[1:0];
        end
    endtask

    // Present a write pattern with the enable low for a full cycle.
    task automatic idle_bus(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk);
        #2;
        cfg_we   = 1'b0;
        cfg_addr = a;
        cfg_data = d;
        @(posedge clk);
    endtask

    // Monitor: compare queued expectations at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                total++;
                if (out_vec !== it.exp) begin
                    bad++;
                    $display("FAIL %s in=%b actual=%b expected=%b", it.req, it.stim, out_vec, it.exp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a, b, c, f1, f2;
        rst_n    = 1'b0;
        cfg_we   = 1'b0;
        cfg_addr = '0;
        cfg_data = '0;
        in_vec   = '0;
        model_clear();
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;

        // R1: reset state gives zero everywhere.
        for (int x = 0; x < 8; x++) check_val(3'(x), 2'b00, "R1");

        // R5: all-absent term on out 0 is constant 1.
        wr(3'd0, 8'h40);
        check_val(3'd0, 2'b01, "R5");
        check_val(3'd5, 2'b01, "R5");
        check_val(3'd7, 2'b01, "R5");

        // R2: input 2 true literal.
        wr(3'd0, 8'h50);
        sweep("R2");

        // R3: input 2 complemented literal.
        wr(3'd0, 8'h60);
        sweep("R3");

        // R4: input 2 true plus kill on input 1.
        wr(3'd0, 8'h5C);
        sweep("R4");

        // R7 and R6: no connections, both outputs inverted.
        wr(3'd0, 8'h00);
        wr(3'd4, 8'h03);
        for (int x = 0; x < 8; x++) check_val(3'(x), 2'b11, "R7");
        wr(3'd4, 8'h00);
        sweep("R6");

        // R6: two terms ORed onto out 0.
        wr(3'd0, 8'h41);
        wr(3'd1, 8'h44);
        sweep("R6");

        // R8: disabled writes and out-of-range addresses change nothing.
        idle_bus(3'd0, 8'hFF);
        idle_bus(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        wr(3'd7, 8'hFF);
        for (int x = 0; x < 8; x++) check_val(3'(x), {1'b0, x[1] | x[0]}, "R8");

        // R9: reference functions.
        wr(3'd0, 8'h58);
        wr(3'd1, 8'hD1);
        wr(3'd2, 8'h85);
        wr(3'd3, 8'h66);
        wr(3'd4, 8'h02);
        for (int x = 0; x < 8; x++) begin
            a  = x[2];
            b  = x[1];
            c  = x[0];
            f1 = (a & ~b) | (a & c) | (~a & b & ~c);
            f2 = ~((a & c) | (b & c));
            check_val(3'(x), {f2, f1}, "R9");
        end

        // R10: outputs follow inputs within the cycle, descending order.
        for (int x = 7; x >= 0; x--) check(3'(x), "R10");

        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule